// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a radix tree of translation tables held in memory. Pages and tables are 4 KiB and every table entry is 8 bytes, so each level resolves a 9-bit index. A request brings a virtual address, the base of the root table and a width select. The select chooses 39-bit addressing, which starts the walk at level 1, or 40-bit addressing, which starts it at level 0.

The walker reads descriptors through a simple memory read port that allows one read in flight at a time. A descriptor with bits 0 and 1 both set points to the next table, or at the last level to the page. Any other descriptor ends the walk with a fault that names the level where it was found. Large block mappings are not supported, so they also fault. A virtual address with bits set above the selected width is rejected at once, without touching memory. The result is reported with a one-cycle done pulse. New work is accepted only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: On a successful walk, rsp_pa[11:0] equals req_va[11:0] of the request.
- R2: With cfg_va40=0 the walk starts at level 1 and a successful walk makes three reads. With cfg_va40=1 it starts at level 0 and makes four reads.
- R3: Each read address is the current table base plus 8 times the level index. The index is VA[47:39] at level 0, VA[38:30] at level 1, VA[29:21] at level 2 and VA[20:12] at level 3. The first table base is req_root.
- R4: The next table base, or the page base, is descriptor bits [47:12] with the low 12 bits zero. Descriptor bits [63:48] and [11:2] are ignored, so rsp_pa[47:12] equals bits [47:12] of the level 3 descriptor.
- R5: A descriptor with bit 0 clear ends the walk with rsp_fault=1, rsp_level equal to the level of that read, and rsp_pa=0.
- R6: A descriptor with bit 0 set and bit 1 clear faults in the same way at every level. At levels 0 to 2 this is an unsupported block. At level 3 it is not a page.
- R7: A request with any VA bit set above the selected width (bit 39 and up for 39-bit, bit 40 and up for 40-bit) raises done with rsp_fault=1 one cycle after acceptance. It reports the starting level in rsp_level and issues no memory read.
- R8: mem_req is high for exactly one cycle per read. No new read is issued until mem_rvalid has returned the previous one. mem_rvalid must arrive at least one cycle after mem_req.
- R9: req_ready is high only when the walker is idle. A request presented while it is busy is ignored. A request held through done is accepted on the cycle after done.
- R10: done is a single-cycle pulse. A success reports rsp_fault=0 and rsp_level=3. The result outputs hold until the next done. After reset req_ready=1, done=0 and mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| cfg_va40 | input | 1 | 1 selects 40-bit, 0 selects 39-bit virtual addresses |
| req_va | input | VA_W | Virtual address to translate |
| req_root | input | PA_W | Root table base (4 KiB aligned) |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | PA_W | Descriptor byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DESC_W | Descriptor returned |
| done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 2 | Level of the fault, or 3 on success |
| rsp_pa | output | PA_W | Physical address, zero on fault |

## Verification
A new request can arrive in the same cycle that done reports the previous walk. The bench provokes this by holding req_valid high through the completion of a walk. It expects req_ready low in the done cycle, high in the next, and the new first read strobe the cycle after that. The result must then match the second request. A further case drives a different request in the middle of a walk with slow memory. It is judged by the read count and the unchanged final address.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W   = 48,
  parameter int VA_W   = 48,
  parameter int DESC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              cfg_va40,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   req_root,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              done,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level,
  output logic [PA_W-1:0]   rsp_pa
);
  localparam int OFF_W = 12;
  localparam int IDX_W = 9;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_t;

  st_t             st;
  logic [1:0]      lvl;
  logic [PA_W-1:0] base;
  logic [VA_W-1:0] va_q;
  logic [IDX_W-1:0] idx;
  logic            range_bad;
  logic            desc_ok;
  logic [PA_W-1:0] next_base;
  logic            unused_bits;

  always_comb begin
    case (lvl)
      2'd0:    idx = va_q[OFF_W+3*IDX_W +: IDX_W];
      2'd1:    idx = va_q[OFF_W+2*IDX_W +: IDX_W];
      2'd2:    idx = va_q[OFF_W+IDX_W   +: IDX_W];
      default: idx = va_q[OFF_W         +: IDX_W];
    endcase
  end

  assign range_bad   = cfg_va40 ? |req_va[VA_W-1:40] : |req_va[VA_W-1:39];
  assign desc_ok     = mem_rdata[0] & mem_rdata[1];
  assign next_base   = {mem_rdata[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign unused_bits = ^{mem_rdata[DESC_W-1:PA_W], mem_rdata[OFF_W-1:2]};

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_ISSUE);
  assign done      = (st == S_RESP);
  assign mem_addr  = base + PA_W'({idx, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= 2'd0;
      base      <= '0;
      va_q      <= '0;
      rsp_fault <= 1'b0;
      rsp_level <= 2'd0;
      rsp_pa    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va;
          if (range_bad) begin
            rsp_fault <= 1'b1;
            rsp_level <= cfg_va40 ? 2'd0 : 2'd1;
            rsp_pa    <= '0;
            st        <= S_RESP;
          end else begin
            lvl  <= cfg_va40 ? 2'd0 : 2'd1;
            base <= req_root;
            st   <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (!desc_ok) begin
            rsp_fault <= 1'b1;
            rsp_level <= lvl;
            rsp_pa    <= '0;
            st        <= S_RESP;
          end else if (lvl == 2'd3) begin
            rsp_fault <= 1'b0;
            rsp_level <= 2'd3;
            rsp_pa    <= {mem_rdata[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            st        <= S_RESP;
          end else begin
            base <= next_base;
            lvl  <= lvl + 2'd1;
            st   <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 48,
  parameter int VA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            cfg_va40,
  input logic [VA_W-1:0] req_va,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic            done,
  input logic            rsp_fault,
  input logic [1:0]      rsp_level,
  input logic [PA_W-1:0] rsp_pa
);
  logic            pend;
  logic [11:0]     off_cap;
  logic            accept;
  logic            bad;

  assign accept = req_valid && req_ready;
  assign bad    = cfg_va40 ? |req_va[VA_W-1:40] : |req_va[VA_W-1:39];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      off_cap <= '0;
    end else begin
      if (mem_req) pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;
      if (accept) off_cap <= req_va[11:0];
    end
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_fault) |-> (rsp_pa[11:0] == off_cap));

  assert_range_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad) |=> (done && rsp_fault && !mem_req));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_success_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_fault) |-> (rsp_level == 2'd3));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_va40(cfg_va40), .req_va(req_va), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .done(done), .rsp_fault(rsp_fault),
  .rsp_level(rsp_level), .rsp_pa(rsp_pa)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic        cfg_va40 = 0;
  logic [47:0] req_va = '0;
  logic [47:0] req_root = '0;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        done;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_pa;

  int n_chk = 0;
  int n_err = 0;
  int rd_count = 0;
  int cur_lat = 1;
  logic [47:0] rd_log [8];

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_va40(cfg_va40), .req_va(req_va), .req_root(req_root),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_pa(rsp_pa)
  );

  localparam int NM = 9;
  localparam logic [47:0] M_ADDR [NM] = '{
    48'h0000_1000_0020, 48'h0008_0003_68D0, 48'h0008_0003_72B0,
    48'h0008_0003_72B8, 48'h0008_0003_6008, 48'h0000_2000_0008,
    48'h0000_3000_0000, 48'h0000_3100_0000, 48'h0000_3200_0008};
  localparam logic [63:0] M_DATA [NM] = '{
    64'h0000_0008_0003_6003, 64'h0000_0008_0003_7003, 64'h0000_0008_0004_0003,
    64'h0000_0008_0004_1001, 64'h0000_0000_0000_0001, 64'h0000_0000_3000_0003,
    64'h0000_0000_3100_0003, 64'h0000_0000_3200_0003, 64'hFFF0_00AB_CDEF_1FFF};

  function automatic logic [63:0] lookup(input logic [47:0] a);
    logic [63:0] d = '0;
    for (int i = 0; i < NM; i++) if (M_ADDR[i] == a) d = M_DATA[i];
    return d;
  endfunction

  initial begin
    mem_rvalid = 0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (rst_n && mem_req) begin
        logic [47:0] a;
        a = mem_addr;
        if (rd_count < 8) rd_log[rd_count] = a;
        rd_count++;
        repeat (cur_lat) @(negedge clk);
        mem_rdata  = lookup(a);
        mem_rvalid = 1;
      end
    end
  end

  typedef struct packed {
    logic        va40;
    logic [47:0] va;
    logic [47:0] root;
    logic [47:0] pa;
    logic        flt;
    logic [1:0]  lvl;
    logic [2:0]  nrd;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 48'h0001_2345_6000, 48'h1000_0000, 48'h0008_0004_0000, 1'b0, 2'd3, 3'd3, 2'd1},
    '{1'b0, 48'h0001_2345_6ABC, 48'h1000_0000, 48'h0008_0004_0ABC, 1'b0, 2'd3, 3'd3, 2'd2},
    '{1'b1, 48'h0080_0000_1234, 48'h2000_0000, 48'h00AB_CDEF_1234, 1'b0, 2'd3, 3'd4, 2'd1},
    '{1'b0, 48'h0080_0000_0000, 48'h1000_0000, 48'h0,             1'b1, 2'd1, 3'd0, 2'd1},
    '{1'b1, 48'h0100_0000_0000, 48'h2000_0000, 48'h0,             1'b1, 2'd0, 3'd0, 2'd1},
    '{1'b0, 48'h0001_4000_0000, 48'h1000_0000, 48'h0,             1'b1, 2'd1, 3'd1, 2'd3},
    '{1'b0, 48'h0001_0020_0000, 48'h1000_0000, 48'h0,             1'b1, 2'd2, 3'd2, 2'd1},
    '{1'b0, 48'h0001_2345_7000, 48'h1000_0000, 48'h0,             1'b1, 2'd3, 3'd3, 2'd2},
    '{1'b1, 48'h0000_0000_0000, 48'h2000_0000, 48'h0,             1'b1, 2'd0, 3'd1, 2'd1},
    '{1'b1, 48'h0001_2345_6000, 48'h1000_0000, 48'h0,             1'b1, 2'd0, 3'd1, 2'd1}};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic va40, input logic [47:0] va, input logic [47:0] root);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_va40 = va40; req_va = va; req_root = root; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R10", "reset req_ready", req_ready, 1);
    chk(done == 0, "R10", "reset done", done, 0);
    chk(mem_req == 0, "R10", "reset mem_req", mem_req, 0);

    for (int v = 0; v < NV; v++) begin
      logic [47:0] exp_first;
      logic [47:0] held;
      cur_lat = int'(VEC[v].lat); rd_count = 0;
      start(VEC[v].va40, VEC[v].va, VEC[v].root);
      wait_done();
      chk(rsp_pa == VEC[v].pa, "R1 R4", $sformatf("vec%0d pa", v), rsp_pa, VEC[v].pa);
      chk(rsp_fault == VEC[v].flt, "R5 R6 R7", $sformatf("vec%0d fault", v), rsp_fault, VEC[v].flt);
      chk(rsp_level == VEC[v].lvl, "R5 R6", $sformatf("vec%0d level", v), rsp_level, VEC[v].lvl);
      chk(rd_count == int'(VEC[v].nrd), "R2 R7", $sformatf("vec%0d reads", v), rd_count, VEC[v].nrd);
      if (VEC[v].nrd != 0) begin
        exp_first = VEC[v].root + (((VEC[v].va >> (VEC[v].va40 ? 39 : 30)) & 48'h1FF) << 3);
        chk(rd_log[0] == exp_first, "R3", $sformatf("vec%0d first addr", v), rd_log[0], exp_first);
      end
      held = rsp_pa;
      @(negedge clk);
      chk(done == 0, "R10", $sformatf("vec%0d done pulse", v), done, 0);
      chk(rsp_pa == held, "R10", $sformatf("vec%0d result hold", v), rsp_pa, held);
    end

    cur_lat = 1; rd_count = 0;
    start(1'b0, 48'h0001_2345_6000, 48'h1000_0000);
    wait_done();
    chk(rd_log[0] == 48'h1000_0020, "R3", "L1 entry addr", rd_log[0], 48'h1000_0020);
    chk(rd_log[1] == 48'h8_0003_68D0, "R3", "L2 entry addr", rd_log[1], 48'h8_0003_68D0);
    chk(rd_log[2] == 48'h8_0003_72B0, "R3", "L3 entry addr", rd_log[2], 48'h8_0003_72B0);

    cur_lat = 3; rd_count = 0;
    start(1'b1, 48'h0080_0000_1234, 48'h2000_0000);
    repeat (2) @(negedge clk);
    req_va = 48'h0000_0000_5000; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    chk(rsp_pa == 48'h00AB_CDEF_1234, "R9", "busy request ignored pa", rsp_pa, 48'h00AB_CDEF_1234);
    chk(rd_count == 4, "R9", "busy request reads", rd_count, 4);
    repeat (6) @(negedge clk);
    chk(rd_count == 4, "R9", "no late walk", rd_count, 4);

    cur_lat = 1; rd_count = 0;
    start(1'b1, 48'h0080_0000_1234, 48'h2000_0000);
    cfg_va40 = 0; req_va = 48'h0001_2345_6ABC; req_root = 48'h1000_0000; req_valid = 1;
    wait_done();
    chk(req_ready == 0, "R9", "ready low during done", req_ready, 0);
    chk(rsp_pa == 48'h00AB_CDEF_1234, "R9", "first result", rsp_pa, 48'h00AB_CDEF_1234);
    @(negedge clk);
    chk(req_ready == 1, "R9", "ready after done", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(mem_req == 1, "R9 R8", "held request accepted", mem_req, 1);
    wait_done();
    chk(rsp_pa == 48'h0008_0004_0ABC, "R9 R1", "second result", rsp_pa, 48'h0008_0004_0ABC);
    chk(rd_count == 7, "R2", "total reads both walks", rd_count, 7);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule